// File: doc/BRIEF.md
# Instruction Cycle Budget Timer

This block works out how many clock cycles an 8-bit-style instruction should occupy, then measures that span out. On a start strobe it takes an instruction class, an addressing mode, the base operand, the two index registers and the final effective address. From these it forms a base count from the joint class and mode, and adds one cycle when an indexed read crosses into a different page.

It latches the result on `cycle_count` and holds `busy` high for exactly that many cycles. `done` pulses in the last of those cycles. A sequencer can use `done` to advance to the next instruction, so an emulation keeps the original timing without executing anything itself.

Top module: `cyc_budget_timer`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `cycle_count` are all 0.
- R2: Penalised read class (code 1) and plain read class (code 2) use these counts: immediate (mode 2) 2, zero page (mode 3) 3, zero page X (4), absolute (6), absolute X (7) and absolute Y (8) 4, pre-indexed indirect (9) 6, post-indexed indirect (10) 5.
- R3: Read-modify-write class (code 3) uses these counts: accumulator (mode 1) 2, zero page 5, zero page X or absolute 6, absolute X 7.
- R4: Store-accumulator class (code 4) uses these counts: zero page 3, zero page X or absolute 4, absolute X or Y 5, pre- or post-indexed indirect 6.
- R5: Some classes ignore the mode: break (code 5) takes 7, call/return (code 6) takes 6, jump (code 7) takes 5, pull (code 8) takes 4 and push (code 9) takes 3. Class 0 and every unassigned class take 2.
- R6: For class 1 in absolute X or absolute Y mode, one cycle is added when bits [15:8] of the base differ from bits [15:8] of the base plus the 8-bit index.
- R7: For class 1 in post-indexed indirect mode, one cycle is added when bits [15:8] of the effective address differ from bits [15:8] of the effective address minus Y.
- R8: Classes 2, 3 and 4 never receive the page-crossing cycle.
- R9: A class 1 to 4 combined with a mode outside its table takes 2 cycles.
- R10: After an accepted start, `busy` is high for exactly `cycle_count` cycles. `done` is high only in the last of them. `cycle_count` holds its value until the next accepted start.
- R11: A start while `busy` is high is ignored: the running count, `cycle_count` and the busy length are unchanged, and no further run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a timing run (accepted when idle) |
| ins_class | input | 4 | Instruction class code |
| addr_mode | input | 4 | Addressing mode code |
| base_addr | input | 16 | Base operand address |
| index_x | input | 8 | X index value |
| index_y | input | 8 | Y index value |
| eff_addr | input | 16 | Final effective address |
| cycle_count | output | 4 | Computed cycle count of the last accepted run |
| busy | output | 1 | High for the length of the run |
| done | output | 1 | Pulses in the final cycle of the run |

## Verification
Every cycle, the assertions check how the run is shaped. They confirm that `done` occurs only inside a run and ends it, that `busy` cannot drop before `done`, that an idle start always opens a run, and that `cycle_count` stays stable and within its legal range while busy. Only the bench scenarios can show that the numbers are correct. These cover each class and mode table entry, the page-crossing and non-crossing index pairs, the classes that must not be penalised, the undefined combinations and the start ignored mid-run.

// File: rtl/cyc_budget_pkg.sv
package cyc_budget_pkg;

  typedef enum logic [3:0] {
    CL_OTHER   = 4'd0,
    CL_READ    = 4'd1,
    CL_READNP  = 4'd2,
    CL_RMW     = 4'd3,
    CL_STORE   = 4'd4,
    CL_BREAK   = 4'd5,
    CL_CALLRET = 4'd6,
    CL_JUMP    = 4'd7,
    CL_PULL    = 4'd8,
    CL_PUSH    = 4'd9
  } ins_class_e;

  typedef enum logic [3:0] {
    AM_IMPL    = 4'd0,
    AM_ACC     = 4'd1,
    AM_IMM     = 4'd2,
    AM_ZP      = 4'd3,
    AM_ZPX     = 4'd4,
    AM_ZPY     = 4'd5,
    AM_ABS     = 4'd6,
    AM_ABSX    = 4'd7,
    AM_ABSY    = 4'd8,
    AM_PREIND  = 4'd9,
    AM_POSTIND = 4'd10,
    AM_REL     = 4'd11,
    AM_INDABS  = 4'd12
  } addr_mode_e;

endpackage

// File: rtl/cyc_base_table.sv
module cyc_base_table
  import cyc_budget_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [3:0]       cls_i,
  input  logic [3:0]       mode_i,
  output logic [CNT_W-1:0] base_o
);

  always_comb begin
    base_o = CNT_W'(2);
    case (cls_i)
      CL_READ, CL_READNP: begin
        case (mode_i)
          AM_IMM:                             base_o = CNT_W'(2);
          AM_ZP:                              base_o = CNT_W'(3);
          AM_ZPX, AM_ABS, AM_ABSX, AM_ABSY:   base_o = CNT_W'(4);
          AM_PREIND:                          base_o = CNT_W'(6);
          AM_POSTIND:                         base_o = CNT_W'(5);
          default:                            base_o = CNT_W'(2);
        endcase
      end
      CL_RMW: begin
        case (mode_i)
          AM_ACC:          base_o = CNT_W'(2);
          AM_ZP:           base_o = CNT_W'(5);
          AM_ZPX, AM_ABS:  base_o = CNT_W'(6);
          AM_ABSX:         base_o = CNT_W'(7);
          default:         base_o = CNT_W'(2);
        endcase
      end
      CL_STORE: begin
        case (mode_i)
          AM_ZP:                 base_o = CNT_W'(3);
          AM_ZPX, AM_ABS:        base_o = CNT_W'(4);
          AM_ABSX, AM_ABSY:      base_o = CNT_W'(5);
          AM_PREIND, AM_POSTIND: base_o = CNT_W'(6);
          default:               base_o = CNT_W'(2);
        endcase
      end
      CL_BREAK:   base_o = CNT_W'(7);
      CL_CALLRET: base_o = CNT_W'(6);
      CL_JUMP:    base_o = CNT_W'(5);
      CL_PULL:    base_o = CNT_W'(4);
      CL_PUSH:    base_o = CNT_W'(3);
      default:    base_o = CNT_W'(2);
    endcase
  end

endmodule

// File: rtl/cyc_page_cross.sv
module cyc_page_cross
  import cyc_budget_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 8
) (
  input  logic [3:0]        cls_i,
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  x_i,
  input  logic [IDX_W-1:0]  y_i,
  input  logic [ADDR_W-1:0] eff_i,
  output logic              pen_o
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] x_ext, y_ext, sum_x, sum_y, back_y;

  assign x_ext  = {{EXT_W{1'b0}}, x_i};
  assign y_ext  = {{EXT_W{1'b0}}, y_i};
  assign sum_x  = base_i + x_ext;
  assign sum_y  = base_i + y_ext;
  assign back_y = eff_i - y_ext;

  always_comb begin
    pen_o = 1'b0;
    if (cls_i == CL_READ) begin
      case (mode_i)
        AM_ABSX:    pen_o = base_i[ADDR_W-1:PAGE_W] != sum_x[ADDR_W-1:PAGE_W];
        AM_ABSY:    pen_o = base_i[ADDR_W-1:PAGE_W] != sum_y[ADDR_W-1:PAGE_W];
        AM_POSTIND: pen_o = eff_i[ADDR_W-1:PAGE_W]  != back_y[ADDR_W-1:PAGE_W];
        default:    pen_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cyc_countdown.sv
module cyc_countdown #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] len_q,
  output logic             busy_q,
  output logic             done_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] rem_q;
  logic             accept;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      len_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      rem_q  <= len_i;
      len_q  <= len_i;
      busy_q <= 1'b1;
      done_q <= (len_i == ONE);
    end else if (busy_q) begin
      rem_q  <= rem_q - ONE;
      done_q <= (rem_q == TWO);
      if (rem_q == ONE) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  // R10
  done_inside_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> busy_q);
  // R10
  done_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !busy_q);
  // R10
  no_early_drop_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !done_q |=> busy_q);
  // R11
  len_held_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !$rose(busy_q) |-> $stable(len_q));

endmodule

// File: rtl/cyc_budget_timer.sv
module cyc_budget_timer
  import cyc_budget_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        ins_class,
  input  logic [3:0]        addr_mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  index_x,
  input  logic [IDX_W-1:0]  index_y,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic [CNT_W-1:0]  cycle_count,
  output logic              busy,
  output logic              done
);

  logic [CNT_W-1:0] base_cyc;
  logic             pen;
  logic [CNT_W-1:0] total;

  cyc_base_table #(.CNT_W(CNT_W)) u_table (
    .cls_i  (ins_class),
    .mode_i (addr_mode),
    .base_o (base_cyc)
  );

  cyc_page_cross #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_cross (
    .cls_i  (ins_class),
    .mode_i (addr_mode),
    .base_i (base_addr),
    .x_i    (index_x),
    .y_i    (index_y),
    .eff_i  (eff_addr),
    .pen_o  (pen)
  );

  assign total = base_cyc + CNT_W'(pen);

  cyc_countdown #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .len_i   (total),
    .len_q   (cycle_count),
    .busy_q  (busy),
    .done_q  (done)
  );

  // R10
  idle_start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && !done);
  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cycle_count >= CNT_W'(2)) && (cycle_count <= CNT_W'(8)));
  // R8
  no_penalty_class_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (ins_class == CL_RMW || ins_class == CL_STORE)
      && addr_mode == AM_ABSX |=> cycle_count == (ins_class == CL_RMW ? CNT_W'(7) : CNT_W'(5)) || $past(ins_class) != ins_class);

endmodule

// File: tb/cyc_budget_timer_bench.sv
module cyc_budget_timer_bench;
  import cyc_budget_pkg::*;

  typedef struct {
    int    exp;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  ins_class = '0;
  logic [3:0]  addr_mode = '0;
  logic [15:0] base_addr = '0;
  logic [7:0]  index_x = '0;
  logic [7:0]  index_y = '0;
  logic [15:0] eff_addr = '0;
  logic [3:0]  cycle_count;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  cyc_budget_timer u_cyc_budget_timer (
    .clk(clk), .rst(rst), .start(start), .ins_class(ins_class),
    .addr_mode(addr_mode), .base_addr(base_addr), .index_x(index_x),
    .index_y(index_y), .eff_addr(eff_addr), .cycle_count(cycle_count),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures each run and compares with the scoreboard head
  int  run_len = 0;
  bit  prev_busy = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        run_len = prev_busy ? run_len + 1 : 1;
        if (done) begin
          if (sb.size() == 0) begin
            check(1'b0, "R11 unexpected run", run_len, 0);
          end else begin
            item_t it;
            it = sb.pop_front();
            check(int'(cycle_count) == it.exp, {it.tag, " count"}, int'(cycle_count), it.exp);
            check(run_len == it.exp, {it.tag, " busy length"}, run_len, it.exp);
          end
        end
      end
      prev_busy = busy;
    end
  end

  task automatic issue(input logic [3:0] c, input logic [3:0] m, input logic [15:0] b,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] e,
                       input int exp, input string tag);
    sb.push_back('{exp, tag});
    @(negedge clk);
    ins_class = c; addr_mode = m; base_addr = b; index_x = x; index_y = y; eff_addr = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(cycle_count == 4'd0, "R1 count", int'(cycle_count), 0);

    // R2 read tables
    issue(CL_READ,   AM_IMM,     16'h0010, 8'h00, 8'h00, 16'h0000, 2, "R2 imm");
    issue(CL_READ,   AM_ZP,      16'h0010, 8'h00, 8'h00, 16'h0000, 3, "R2 zp");
    issue(CL_READ,   AM_ZPX,     16'h0010, 8'h05, 8'h00, 16'h0000, 4, "R2 zpx");
    issue(CL_READ,   AM_ABS,     16'h1234, 8'h00, 8'h00, 16'h0000, 4, "R2 abs");
    issue(CL_READ,   AM_ABSX,    16'h1200, 8'h20, 8'h00, 16'h0000, 4, "R2 absx same page");
    issue(CL_READNP, AM_PREIND,  16'h0040, 8'h02, 8'h00, 16'h2000, 6, "R2 preind");
    issue(CL_READ,   AM_POSTIND, 16'h0040, 8'h00, 8'h10, 16'h4025, 5, "R2 postind same page");
    // R3 rmw
    issue(CL_RMW, AM_ACC,  16'h0000, 8'h00, 8'h00, 16'h0000, 2, "R3 acc");
    issue(CL_RMW, AM_ZP,   16'h0020, 8'h00, 8'h00, 16'h0000, 5, "R3 zp");
    issue(CL_RMW, AM_ABS,  16'h0300, 8'h00, 8'h00, 16'h0000, 6, "R3 abs");
    // R4 store
    issue(CL_STORE, AM_ZP,      16'h0020, 8'h00, 8'h00, 16'h0000, 3, "R4 zp");
    issue(CL_STORE, AM_ZPX,     16'h0020, 8'h01, 8'h00, 16'h0000, 4, "R4 zpx");
    issue(CL_STORE, AM_ABSY,    16'h0300, 8'h00, 8'h04, 16'h0000, 5, "R4 absy");
    issue(CL_STORE, AM_POSTIND, 16'h0020, 8'h00, 8'h10, 16'h4005, 6, "R4 postind");
    // R5 fixed classes
    issue(CL_BREAK,   AM_IMPL,   16'h0000, 8'h00, 8'h00, 16'h0000, 7, "R5 break");
    issue(CL_CALLRET, AM_ABS,    16'h8000, 8'h00, 8'h00, 16'h0000, 6, "R5 call");
    issue(CL_JUMP,    AM_INDABS, 16'h8000, 8'h00, 8'h00, 16'h0000, 5, "R5 jump");
    issue(CL_PULL,    AM_IMPL,   16'h0000, 8'h00, 8'h00, 16'h0000, 4, "R5 pull");
    issue(CL_PUSH,    AM_IMPL,   16'h0000, 8'h00, 8'h00, 16'h0000, 3, "R5 push");
    issue(CL_OTHER,   AM_REL,    16'h0000, 8'h00, 8'h00, 16'h0000, 2, "R5 other");
    issue(4'd14,      AM_ABS,    16'h0000, 8'h00, 8'h00, 16'h0000, 2, "R5 unassigned class");
    // R6 penalty on absolute indexed reads
    issue(CL_READ, AM_ABSX, 16'h12F0, 8'h20, 8'h00, 16'h0000, 5, "R6 absx cross");
    issue(CL_READ, AM_ABSY, 16'h30FF, 8'h00, 8'h01, 16'h0000, 5, "R6 absy cross");
    issue(CL_READ, AM_ABSY, 16'hFFF0, 8'h00, 8'h20, 16'h0000, 5, "R6 absy wrap");
    // R7 post-indexed penalty
    issue(CL_READ, AM_POSTIND, 16'h0040, 8'h00, 8'h10, 16'h4005, 6, "R7 postind cross");
    // R8 no penalty classes
    issue(CL_READNP, AM_ABSX, 16'h12F0, 8'h20, 8'h00, 16'h0000, 4, "R8 plain read");
    issue(CL_RMW,    AM_ABSX, 16'h12F0, 8'h20, 8'h00, 16'h0000, 7, "R8 rmw");
    issue(CL_STORE,  AM_ABSX, 16'h12F0, 8'h20, 8'h00, 16'h0000, 5, "R8 store");
    // R9 undefined combinations
    issue(CL_RMW,   AM_IMM, 16'h0000, 8'h00, 8'h00, 16'h0000, 2, "R9 rmw imm");
    issue(CL_STORE, AM_ACC, 16'h0000, 8'h00, 8'h00, 16'h0000, 2, "R9 store acc");
    issue(CL_READ,  AM_ZPY, 16'h0000, 8'h00, 8'h00, 16'h0000, 2, "R9 read zpy");

    // R11 start while busy is ignored
    sb.push_back('{7, "R11 break with ignored start"});
    @(negedge clk);
    ins_class = CL_BREAK; addr_mode = AM_IMPL; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    ins_class = CL_PUSH; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cycle_count == 4'd7, "R11 count held", int'(cycle_count), 7);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R11 no second run", int'(busy), 0);
    check(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
    check(cycle_count == 4'd7, "R10 count held after run", int'(cycle_count), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule